// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side access port and a PCI host controller's configuration engine. A CPU access that lands in the downstream configuration window carries only a 16-bit offset. The block puts a 16-bit upper half, held in a mapping word that the surrounding register file supplies, above that offset to form a 32-bit intermediate address. It reads the slot select as a one-hot field in the upper bits of that address and turns the lowest asserted bit into a binary device number. It then builds a type-0 configuration request word: an enable bit, the local bus number, the device, the function and the dword register index.

Reads and writes of byte, halfword and word size are accepted one at a time. Each accepted access is latched, checked and either issued downstream as one configuration cycle or refused. A refused read returns all-ones at the access width. A refused write is dropped. A mode bit in the mapping word blocks every translation. An empty slot select field, a misaligned access or an unsupported size is rejected and raises an error flag. Every cycle that is issued also produces a one-cycle pulse. The bridge's own status register uses that pulse to clear its received-master-abort and received-target-abort bits.

Top module: `cfg_xlate_top`

## Requirements
- R1: The intermediate address is {map_cfg[15:0], req_addr[15:0]}. An issued cycle carries cyc_addr with bit 31 = 1, bits 30:24 = 0, bus_num at 23:16, the device number at 15:11, intermediate bits 10:8 (function) at 10:8, intermediate bits 7:2 (dword index) at 7:2, and bits 1:0 = 0.
- R2: The device number is the index of the lowest set bit of intermediate bits 31:11 (the 21-bit slot select, index 0 = bit 11). Higher set bits are ignored.
- R3: When map_cfg[16] = 1, no cycle is issued and resp_err = 0. A read returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for req_size 0 (byte), 1 (halfword) or 2 (word), and a write is dropped with resp_rdata = 0. This mode takes priority over the checks of R4 and R5.
- R4: When the slot select field is all zero, no cycle is issued and resp_err = 1. A read returns all-ones at its width as in R3, and a write returns 0.
- R5: A halfword access with req_addr[0] = 1, a word access with req_addr[1:0] != 0, or req_size = 3 is rejected the same way as R4, with resp_err = 1.
- R6: A read that is issued completes when dn_rvalid is high. resp_rdata is then dn_rdata masked to the access width (the upper bits are zero) and resp_err = 0.
- R7: stat_clr pulses high for exactly one cycle, in the cycle after each issued cycle's handshake (cyc_valid and cyc_ready both high). It never pulses otherwise.
- R8: An issued cycle carries the access's write flag on cyc_write, req_size on cyc_size, req_addr[1:0] on cyc_lane and, for writes, req_wdata unchanged on cyc_wdata. A write completes with resp_err = 0 and resp_rdata = 0 once its cycle is accepted.
- R9: Only one access is in flight at a time. req_ready is high only while idle. cyc_valid and resp_valid, once raised, stay high with stable contents until accepted. After reset the block is idle with cyc_valid and resp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU access request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unsupported |
| req_addr | input | 16 | Offset inside the configuration window |
| req_wdata | input | 32 | Write data, right-justified |
| map_cfg | input | 17 | Bits 15:0 upper address half, bit 16 block mode |
| bus_num | input | 8 | Local bus number placed in the request word |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | CPU takes the response |
| resp_rdata | output | 32 | Read data or all-ones fill |
| resp_err | output | 1 | Access rejected as invalid |
| cyc_valid | output | 1 | Configuration cycle request valid |
| cyc_ready | input | 1 | Configuration engine takes the request |
| cyc_addr | output | 32 | Type-0 request word with enable bit |
| cyc_write | output | 1 | Cycle direction |
| cyc_size | output | 2 | Cycle access size |
| cyc_lane | output | 2 | Byte offset inside the dword |
| cyc_wdata | output | 32 | Cycle write data |
| dn_rvalid | input | 1 | Read data returned by the configuration engine |
| dn_rdata | input | 32 | Returned read data |
| stat_clr | output | 1 | Pulse that clears the two abort status bits |

## Verification
The block-mode check and the invalid-address check can both hold for one request. The bench provokes this with map_cfg[16] set and the slot select field all zero. It expects no cycle, all-ones read data and resp_err low, so the mode check must win. Requests with several slot select bits set, one bit in the CPU half and one in the mapping half, pit the encoder's lowest-bit rule against the other set bits. Stalls on cyc_ready and resp_ready make the issue and response stages hold their values while the next request waits.

// File: rtl/cfg_xlate_pkg.sv
// Package: shared constants, state encoding and helper functions of the
// configuration address translator. Assumes a 32-bit intermediate address
// made of two 16-bit halves.
package cfg_xlate_pkg;

    localparam int HALF_W    = 16;
    localparam int DATA_W    = 32;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int SEL_LSB   = 11;
    localparam int SEL_W     = 2 * HALF_W - SEL_LSB;
    localparam int MAP_W     = HALF_W + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RESP  = 3'd4
    } xl_state_e;

    // All-ones fill pattern for an access of the given size.
    function automatic logic [DATA_W-1:0] fill_ones(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // True when size and byte offset do not form a legal access.
    function automatic logic size_reject(input logic [1:0] sz, input logic [1:0] lane);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lane[0];
            SZ_WORD: return |lane;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/cfg_lsb_enc.sv
// Lowest-set-bit encoder. Returns the index of the least significant set
// bit of vec and flags an all-zero input. Assumes OUT_W can hold IN_W-1.
module cfg_lsb_enc #(
    parameter int IN_W  = 21,
    parameter int OUT_W = 5
) (
    input  logic [IN_W-1:0]  vec,
    output logic [OUT_W-1:0] idx,
    output logic             none
);

    logic [IN_W-1:0] below;
    logic [IN_W-1:0] first;

    assign below[0] = 1'b0;

    // Ripple chain: below[i] says some lower bit is already set.
    for (genvar g = 1; g < IN_W; g++) begin : g_chain
        assign below[g] = below[g-1] | vec[g-1];
    end

    assign first = vec & ~below;
    assign none  = ~|vec;

    // Fold the single surviving bit into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (first[i]) idx = idx | OUT_W'(i);
        end
    end

endmodule

// File: rtl/cfg_xlate_decode.sv
// Combinational translation of a latched access into a type-0 request
// word. Assumes inputs are held stable by the controller while in use.
module cfg_xlate_decode
    import cfg_xlate_pkg::*;
(
    input  logic [HALF_W-1:0] lo_addr,
    input  logic [HALF_W-1:0] map_hi,
    input  logic [BUS_W-1:0]  bus,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] word,
    output logic              sel_none,
    output logic              size_bad
);

    localparam int PAD_W = DATA_W - 1 - BUS_W - DEV_W - SEL_LSB;

    logic [SEL_W-1:0] sel;
    logic [DEV_W-1:0] dev;

    // Slot select spans the mapping half and the top of the CPU offset.
    assign sel = {map_hi, lo_addr[HALF_W-1:SEL_LSB]};

    cfg_lsb_enc #(
        .IN_W  (SEL_W),
        .OUT_W (DEV_W)
    ) u_enc (
        .vec  (sel),
        .idx  (dev),
        .none (sel_none)
    );

    // Request word: enable, padding, bus, device, function, dword index.
    assign word = {1'b1, {PAD_W{1'b0}}, bus, dev,
                   lo_addr[SEL_LSB-1:8], lo_addr[7:2], 2'b00};

    assign size_bad = size_reject(size, lo_addr[1:0]);

endmodule

// File: rtl/cfg_xlate_ctrl.sv
// Access controller: latches one request, decides between issue, block
// and reject, runs the downstream and response handshakes, and pulses the
// status clear after each issued cycle. Assumes one access in flight.
module cfg_xlate_ctrl
    import cfg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [HALF_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MAP_W-1:0]  req_map,
    input  logic [BUS_W-1:0]  req_bus,
    output logic [HALF_W-1:0] q_addr,
    output logic [HALF_W-1:0] q_map_hi,
    output logic              q_block,
    output logic [BUS_W-1:0]  q_bus,
    output logic [1:0]        q_size,
    input  logic              sel_none,
    input  logic              size_bad,
    output logic              cyc_valid,
    input  logic              cyc_ready,
    output logic              cyc_write,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_err,
    output logic              stat_clr
);

    xl_state_e         st;
    logic              q_write;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_err;
    logic              clr_q;

    assign req_ready  = (st == ST_IDLE);
    assign cyc_valid  = (st == ST_ISSUE);
    assign resp_valid = (st == ST_RESP);
    assign cyc_write  = q_write;
    assign cyc_wdata  = q_wdata;
    assign resp_rdata = rsp_data;
    assign resp_err   = rsp_err;
    assign stat_clr   = clr_q;

    // Sequencer and request/response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            q_write  <= 1'b0;
            q_size   <= '0;
            q_addr   <= '0;
            q_map_hi <= '0;
            q_block  <= 1'b0;
            q_bus    <= '0;
            q_wdata  <= '0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write  <= req_write;
                        q_size   <= req_size;
                        q_addr   <= req_addr;
                        q_map_hi <= req_map[HALF_W-1:0];
                        q_block  <= req_map[HALF_W];
                        q_bus    <= req_bus;
                        q_wdata  <= req_wdata;
                        st       <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (q_block) begin
                        rsp_data <= q_write ? '0 : fill_ones(q_size);
                        rsp_err  <= 1'b0;
                        st       <= ST_RESP;
                    end else if (sel_none || size_bad) begin
                        rsp_data <= q_write ? '0 : fill_ones(q_size);
                        rsp_err  <= 1'b1;
                        st       <= ST_RESP;
                    end else begin
                        st <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cyc_ready) begin
                        clr_q <= 1'b1;
                        if (q_write) begin
                            rsp_data <= '0;
                            rsp_err  <= 1'b0;
                            st       <= ST_RESP;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (dn_rvalid) begin
                        rsp_data <= dn_rdata & fill_ones(q_size);
                        rsp_err  <= 1'b0;
                        st       <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (resp_ready) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cyc_valid && !resp_valid)); // R9
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata) && $stable(resp_err))); // R9
    AST_CLR_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> $past(cyc_valid && cyc_ready)); // R7
    AST_ISSUE_ONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_ready) |=> (stat_clr && !cyc_valid)); // R7

endmodule

// File: rtl/cfg_xlate_top.sv
// Top of the configuration address translator: ties the controller to the
// decode path and exposes the CPU, downstream and status-clear ports.
// Assumes the mapping word and bus number are valid while req_valid is high.
module cfg_xlate_top
    import cfg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [15:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [16:0]       map_cfg,
    input  logic [7:0]        bus_num,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [31:0]       resp_rdata,
    output logic              resp_err,
    output logic              cyc_valid,
    input  logic              cyc_ready,
    output logic [31:0]       cyc_addr,
    output logic              cyc_write,
    output logic [1:0]        cyc_size,
    output logic [1:0]        cyc_lane,
    output logic [31:0]       cyc_wdata,
    input  logic              dn_rvalid,
    input  logic [31:0]       dn_rdata,
    output logic              stat_clr
);

    logic [HALF_W-1:0] q_addr;
    logic [HALF_W-1:0] q_map_hi;
    logic              q_block;
    logic [BUS_W-1:0]  q_bus;
    logic [1:0]        q_size;
    logic              sel_none;
    logic              size_bad;
    logic [31:0]       sel_wide;

    cfg_xlate_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_map    (map_cfg),
        .req_bus    (bus_num),
        .q_addr     (q_addr),
        .q_map_hi   (q_map_hi),
        .q_block    (q_block),
        .q_bus      (q_bus),
        .q_size     (q_size),
        .sel_none   (sel_none),
        .size_bad   (size_bad),
        .cyc_valid  (cyc_valid),
        .cyc_ready  (cyc_ready),
        .cyc_write  (cyc_write),
        .cyc_wdata  (cyc_wdata),
        .dn_rvalid  (dn_rvalid),
        .dn_rdata   (dn_rdata),
        .resp_valid (resp_valid),
        .resp_ready (resp_ready),
        .resp_rdata (resp_rdata),
        .resp_err   (resp_err),
        .stat_clr   (stat_clr)
    );

    cfg_xlate_decode u_dec (
        .lo_addr  (q_addr),
        .map_hi   (q_map_hi),
        .bus      (q_bus),
        .size     (q_size),
        .word     (cyc_addr),
        .sel_none (sel_none),
        .size_bad (size_bad)
    );

    assign cyc_size = q_size;
    assign cyc_lane = q_addr[1:0];

    // Zero-extended slot select used by the encoder checks below.
    assign sel_wide = {11'b0, q_map_hi, q_addr[HALF_W-1:SEL_LSB]};

    AST_DEV_HITS_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> sel_wide[cyc_addr[15:11]]); // R2
    AST_DEV_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> ((sel_wide & ((32'd1 << cyc_addr[15:11]) - 32'd1)) == 32'd0)); // R2
    AST_NO_CYCLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> !q_block); // R3
    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_wdata))); // R9
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && q_size == SZ_BYTE) |-> (resp_rdata[31:8] == 24'd0)); // R6
    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> !$past(stat_clr)); // R4

endmodule

// File: tb/sim_cfg_xlate_top.sv
`timescale 1ns/1ps
module sim_cfg_xlate_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [16:0] map_cfg = 17'h0;
    logic [7:0]  bus_num = 8'h0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [31:0] resp_rdata;
    logic        resp_err;
    logic        cyc_valid;
    logic        cyc_ready = 1'b0;
    logic [31:0] cyc_addr;
    logic        cyc_write;
    logic [1:0]  cyc_size;
    logic [1:0]  cyc_lane;
    logic [31:0] cyc_wdata;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = 32'h0;
    logic        stat_clr;

    int checks = 0;
    int errors = 0;
    int hs_count = 0;
    int clr_count = 0;
    bit done = 1'b0;

    logic [68:0] exp_cyc[$];
    string       cyc_tag[$];
    logic [32:0] exp_rsp[$];
    string       rsp_tag[$];

    always #5 clk = ~clk;

    cfg_xlate_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .map_cfg(map_cfg), .bus_num(bus_num),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
        .resp_err(resp_err), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
        .cyc_addr(cyc_addr), .cyc_write(cyc_write), .cyc_size(cyc_size),
        .cyc_lane(cyc_lane), .cyc_wdata(cyc_wdata), .dn_rvalid(dn_rvalid),
        .dn_rdata(dn_rdata), .stat_clr(stat_clr)
    );

    function automatic logic [31:0] width_mask(input logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    // Downstream data model: byte swap with a fixed scramble.
    function automatic logic [31:0] dn_model(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]} ^ 32'h5A3C_96E1;
    endfunction

    // Expected request word from R1 and R2.
    function automatic logic [31:0] exp_word(input logic [15:0] mh, input logic [15:0] a,
                                             input logic [7:0] b);
        logic [31:0] inter;
        int dev;
        inter = {mh, a};
        dev = 0;
        for (int i = 31; i >= 11; i--) if (inter[i]) dev = i - 11;
        return 32'h8000_0000 | (32'(b) << 16) | (32'(dev) << 11) | (inter & 32'h0000_07FC);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: computes expectations, pushes them, then performs the request handshake.
    task automatic do_acc(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                          input logic [16:0] mp, input logic [7:0] b,
                          input logic [31:0] wd, input string tag);
        logic bad;
        logic [31:0] w;
        w = exp_word(mp[15:0], a, b);
        bad = ({mp[15:0], a[15:11]} == 21'd0) || (sz == 2'd3) ||
              (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
        if (mp[16]) begin
            exp_rsp.push_back({1'b0, wr ? 32'h0 : width_mask(sz)});
        end else if (bad) begin
            exp_rsp.push_back({1'b1, wr ? 32'h0 : width_mask(sz)});
        end else begin
            exp_cyc.push_back({wr, sz, a[1:0], wd, w});
            cyc_tag.push_back(tag);
            exp_rsp.push_back({1'b0, wr ? 32'h0 : (dn_model(w) & width_mask(sz))});
        end
        rsp_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        map_cfg = mp; bus_num = b; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        map_cfg = 17'h1_FFFF; bus_num = 8'hEE;
    endtask

    // Downstream responder and status-clear monitor.
    initial begin
        bit pend = 1'b0;
        bit last_hs = 1'b0;
        int n = 0;
        logic [31:0] rd_word = 32'h0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                n++;
                if (stat_clr) begin
                    clr_count++;
                    chk(last_hs, "R7 clear pulse without preceding issue", 32'(stat_clr), 32'(last_hs));
                end
                last_hs = 1'b0;
                dn_rvalid = pend;
                dn_rdata = pend ? dn_model(rd_word) : 32'hDEAD_BEEF;
                pend = 1'b0;
                cyc_ready = (n % 3) != 0;
                if (cyc_valid && cyc_ready) begin
                    hs_count++;
                    last_hs = 1'b1;
                    if (exp_cyc.size() == 0) begin
                        chk(1'b0, "R3/R4 unexpected cycle issued", cyc_addr, 32'h0);
                    end else begin
                        logic [68:0] e;
                        string t;
                        e = exp_cyc.pop_front();
                        t = cyc_tag.pop_front();
                        chk(cyc_addr == e[31:0], {t, " R1 cycle address"}, cyc_addr, e[31:0]);
                        chk(cyc_write == e[68] && cyc_size == e[67:66] && cyc_lane == e[65:64],
                            {t, " R8 cycle controls"}, {27'b0, cyc_write, cyc_size, cyc_lane},
                            {27'b0, e[68:64]});
                        if (e[68]) chk(cyc_wdata == e[63:32], {t, " R8 write data"}, cyc_wdata, e[63:32]);
                        if (!cyc_write) begin
                            pend = 1'b1;
                            rd_word = cyc_addr;
                        end
                    end
                end
            end
        end
    end

    // Response monitor: pops the scoreboard as the design answers.
    initial begin
        int m = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                m++;
                resp_ready = (m % 4) != 1;
                if (resp_valid && resp_ready) begin
                    if (exp_rsp.size() == 0) begin
                        chk(1'b0, "R9 unexpected response", resp_rdata, 32'h0);
                    end else begin
                        logic [32:0] e;
                        string t;
                        e = exp_rsp.pop_front();
                        t = rsp_tag.pop_front();
                        chk(resp_rdata == e[31:0], {t, " read data"}, resp_rdata, e[31:0]);
                        chk(resp_err == e[32], {t, " error flag"}, 32'(resp_err), 32'(e[32]));
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !cyc_valid && !resp_valid, "R9 reset state",
            {29'b0, req_ready, cyc_valid, resp_valid}, 32'h4);

        do_acc(1'b0, 2'd2, 16'h0108, 17'h0_0002, 8'h3A, 32'h0, "R1 R6 word read");
        do_acc(1'b1, 2'd0, 16'h0A13, 17'h0_0010, 8'h3A, 32'h0000_00A5, "R8 byte write lane3");
        do_acc(1'b0, 2'd1, 16'h0306, 17'h0_0100, 8'h01, 32'h0, "R6 half read");
        do_acc(1'b0, 2'd0, 16'hF801, 17'h0_00F0, 8'h7F, 32'h0, "R2 lowest bit in cpu half");
        do_acc(1'b0, 2'd2, 16'h00FC, 17'h0_8000, 8'hFF, 32'h0, "R2 top select bit");
        do_acc(1'b0, 2'd2, 16'h0044, 17'h0_A0C0, 8'h10, 32'h0, "R2 lowest bit in map half");
        do_acc(1'b1, 2'd2, 16'h17A8, 17'h0_0400, 8'h55, 32'hCAFE_F00D, "R8 word write");
        do_acc(1'b1, 2'd1, 16'h0802, 17'h0_0000, 8'h02, 32'h0000_BEEF, "R8 half write");
        do_acc(1'b0, 2'd0, 16'h0108, 17'h1_0002, 8'h3A, 32'h0, "R3 blocked byte read");
        do_acc(1'b0, 2'd1, 16'h0108, 17'h1_0002, 8'h3A, 32'h0, "R3 blocked half read");
        do_acc(1'b0, 2'd2, 16'h0108, 17'h1_0002, 8'h3A, 32'h0, "R3 blocked word read");
        do_acc(1'b1, 2'd2, 16'h0108, 17'h1_0002, 8'h3A, 32'h1234_5678, "R3 blocked write");
        do_acc(1'b0, 2'd2, 16'h0004, 17'h1_0000, 8'h3A, 32'h0, "R3 block beats empty select");
        do_acc(1'b0, 2'd2, 16'h0004, 17'h0_0000, 8'h3A, 32'h0, "R4 empty select word read");
        do_acc(1'b0, 2'd0, 16'h07FF, 17'h0_0000, 8'h3A, 32'h0, "R4 empty select byte read");
        do_acc(1'b1, 2'd2, 16'h0010, 17'h0_0000, 8'h3A, 32'hFFFF_0000, "R4 empty select write");
        do_acc(1'b0, 2'd1, 16'h0801, 17'h0_0000, 8'h3A, 32'h0, "R5 misaligned half");
        do_acc(1'b0, 2'd2, 16'h0802, 17'h0_0000, 8'h3A, 32'h0, "R5 misaligned word");
        do_acc(1'b1, 2'd3, 16'h0800, 17'h0_0000, 8'h3A, 32'h0, "R5 reserved size");
        do_acc(1'b0, 2'd2, 16'h2820, 17'h0_0001, 8'h09, 32'h0, "R1 read after rejects");

        for (int k = 0; k < 5000 && exp_rsp.size() != 0; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(exp_rsp.size() == 0, "R9 responses outstanding", 32'(exp_rsp.size()), 32'h0);
        chk(exp_cyc.size() == 0, "R3 cycles missing", 32'(exp_cyc.size()), 32'h0);
        chk(clr_count == hs_count, "R7 clear pulse count", 32'(clr_count), 32'(hs_count));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule